// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block is the digital control core of a synchronous buck power stage. It takes a decoded PWM level (low, high or mid-level tri-state) and turns it into two gate enables, one for the high-side switch and one for the low-side switch. It never lets the two switches conduct at once. Dead time is not a blind timer. Each hand-over waits until the sensed feedback shows that the outgoing switch is really off, then counts a short programmable delay before the incoming switch turns on.

A mid-level PWM is only accepted once it has persisted for a hold-off window, so noise near the middle threshold cannot shut the stage down. When the level leaves tri-state, the gate it selects is enabled after a propagation delay. With the mode select low, a high-to-tri-state move runs the low side as an emulated diode: the low-side gate stays on until a synchronised zero-cross indication arrives. Zero-cross pulses are ignored for a blanking window after the low side turns on. An output enable and an undervoltage flag force both gates off. Every delay is a parameter counted in clock cycles.

States: OFF (forced off), TRI (both off, tri-state), EXIT (propagation delay out of tri-state), LS_ON, HS_WAIT (low side released, waiting for its feedback plus dead time), HS_ON, LS_WAIT (high side released, waiting for switch-node feedback plus dead time), DM_WAIT (same wait, leading to emulation), DEMU (low side on as emulated diode). Transitions: any state to OFF when not enabled; OFF to TRI; TRI to EXIT on a valid level; EXIT to TRI on mid level, or to HS_ON or LS_ON when the delay ends; LS_ON to HS_WAIT on high or to TRI on mid; HS_WAIT to HS_ON when the delay ends, to LS_ON on low, or to TRI on mid; HS_ON to LS_WAIT on low, or on mid to TRI (continuous mode) or DM_WAIT (emulation mode); LS_WAIT to LS_ON when the delay ends, to HS_WAIT on high, or to TRI on mid; DM_WAIT to DEMU when the delay ends, to HS_WAIT on high, to LS_WAIT on low, or to TRI when continuous mode is selected; DEMU to TRI on an unblanked zero cross or when continuous mode is selected, to HS_WAIT on high, or to LS_ON on low.

Top module: `buck_gate_seq`

## Requirements
- R1: While `out_en` is low, both gates read 0 from the first clock edge that samples it, whatever `pwm_lvl` and `ccm_sel` do.
- R2: While `uv_flag` is high, both gates read 0 from the first clock edge that samples it.
- R3: On a low-to-high level change, `ls_gate` drops 2 cycles after the input changes. `hs_gate` then rises exactly DT_HS_CYC cycles after the synchronised low-side feedback (`fb_ls_low`, two-flop delay) reads 1, and never earlier.
- R4: On a high-to-low level change, `hs_gate` drops 2 cycles after the input changes. `ls_gate` then rises exactly DT_LS_CYC cycles after the synchronised switch-node feedback (`fb_sw_low`) reads 1, and never earlier.
- R5: `pwm_lvl` encoding is 2'b00 low, 2'b01 high, and 2'b10 or 2'b11 mid-level. A mid level takes effect only after TRI_HOLD_CYC consecutive sampled cycles. A shorter mid-level run leaves the gates unchanged.
- R6: Out of reset, or on leaving tri-state, the gate chosen by the new level rises TRI_EXIT_CYC+2 cycles after the level (or enable) changes. During that time both gates stay 0.
- R7: With `ccm_sel` high, a qualified mid level turns both gates off, from either gate being on, and they stay off.
- R8: With `ccm_sel` low and a high-to-mid move, `hs_gate` drops. `ls_gate` rises after the switch-node feedback plus DT_LS_CYC, and stays on while no zero cross is seen.
- R9: In emulation, an unblanked zero cross drops `ls_gate` 3 cycles after `fb_zc` rises (two-flop sync plus one state edge). Both gates then stay off.
- R10: A zero cross present while the emulated diode turns on is ignored until the low side has been on for ZCD_BLANK_CYC+1 clock edges.
- R11: With `ccm_sel` low and a low-to-mid move, both gates turn off.
- R12: `hs_gate` and `ls_gate` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid |
| out_en | input | 1 | Active-low disable: 0 forces both gates off |
| ccm_sel | input | 1 | 1 continuous conduction, 0 low-side diode emulation |
| uv_flag | input | 1 | Undervoltage indication, holds both gates off |
| fb_ls_low | input | 1 | Asynchronous: low-side gate sensed below threshold |
| fb_sw_low | input | 1 | Asynchronous: switch node sensed below threshold |
| fb_zc | input | 1 | Asynchronous: inductor current zero cross detected |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The assertions assume that `pwm_lvl`, `out_en`, `ccm_sel` and `uv_flag` are already synchronous to `clk`, and that the three feedback inputs move at most once per cycle and settle between edges. The bench drives every input on the falling edge and changes each feedback signal only after the matching gate change is visible at the ports, which is how a real power stage would respond. The zero-cross input is raised only while the emulated diode is on or about to turn on, so the blanking and non-blanking cases are separated cleanly.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    // Qualified PWM level seen by the sequencer
    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_HI  = 2'b01,
        LVL_MID = 2'b10
    } lvl_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_TRI,
        ST_EXIT,
        ST_LS_ON,
        ST_HS_WAIT,
        ST_HS_ON,
        ST_LS_WAIT,
        ST_DM_WAIT,
        ST_DEMU
    } seq_state_e;

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b]   <= 1'b0;
                sync_out[b] <= 1'b0;
            end else begin
                stage1[b]   <= async_in[b];
                sync_out[b] <= stage1[b];
            end
        end
    end

endmodule

// File: rtl/gdrv_tri_filter.sv
module gdrv_tri_filter
    import gdrv_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_raw,
    output lvl_e       lvl_q
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] mid_run;
    logic          raw_is_mid;

    assign raw_is_mid = pwm_raw[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= LVL_MID;
            mid_run <= '0;
        end else if (!raw_is_mid) begin
            mid_run <= '0;
            lvl_q   <= pwm_raw[0] ? LVL_HI : LVL_LO;
        end else if (mid_run == CW'(HOLD_CYC - 1)) begin
            lvl_q   <= LVL_MID;
        end else begin
            mid_run <= mid_run + 1'b1;
        end
    end

    // A newly qualified mid level must come from a mid-level sample
    assert_tri_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == LVL_MID && $past(lvl_q) != LVL_MID) |-> $past(pwm_raw[1]));

endmodule

// File: rtl/gdrv_fsm.sv
module gdrv_fsm
    import gdrv_pkg::*;
#(
    parameter int unsigned DT_HS_CYC     = 2,
    parameter int unsigned DT_LS_CYC     = 2,
    parameter int unsigned TRI_EXIT_CYC  = 4,
    parameter int unsigned ZCD_BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_ok,
    input  logic ccm_sel,
    input  lvl_e lvl,
    input  logic ls_low_s,
    input  logic sw_low_s,
    input  logic zc_s,
    output logic hs_on,
    output logic ls_on
);
    localparam int unsigned MAX_AB = (DT_HS_CYC > DT_LS_CYC) ? DT_HS_CYC : DT_LS_CYC;
    localparam int unsigned MAX_CD = (TRI_EXIT_CYC > ZCD_BLANK_CYC) ? TRI_EXIT_CYC : ZCD_BLANK_CYC;
    localparam int unsigned MAX_V  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CW     = $clog2(MAX_V + 1);

    seq_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= (state_nxt != state) ? '0 : cnt_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (!en_ok) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  state_nxt = ST_TRI;
                ST_TRI:  if (lvl != LVL_MID) state_nxt = ST_EXIT;
                ST_EXIT: begin
                    if (lvl == LVL_MID)                  state_nxt = ST_TRI;
                    else if (cnt == CW'(TRI_EXIT_CYC - 1)) state_nxt = (lvl == LVL_HI) ? ST_HS_ON : ST_LS_ON;
                    else                                 cnt_nxt = cnt + 1'b1;
                end
                ST_LS_ON: begin
                    if (lvl == LVL_HI)       state_nxt = ST_HS_WAIT;
                    else if (lvl == LVL_MID) state_nxt = ST_TRI;
                end
                ST_HS_WAIT: begin
                    if (lvl == LVL_LO)                  state_nxt = ST_LS_ON;
                    else if (lvl == LVL_MID)            state_nxt = ST_TRI;
                    else if (!ls_low_s)                 cnt_nxt = '0;
                    else if (cnt == CW'(DT_HS_CYC - 1)) state_nxt = ST_HS_ON;
                    else                                cnt_nxt = cnt + 1'b1;
                end
                ST_HS_ON: begin
                    if (lvl == LVL_LO)       state_nxt = ST_LS_WAIT;
                    else if (lvl == LVL_MID) state_nxt = ccm_sel ? ST_TRI : ST_DM_WAIT;
                end
                ST_LS_WAIT: begin
                    if (lvl == LVL_HI)                  state_nxt = ST_HS_WAIT;
                    else if (lvl == LVL_MID)            state_nxt = ST_TRI;
                    else if (!sw_low_s)                 cnt_nxt = '0;
                    else if (cnt == CW'(DT_LS_CYC - 1)) state_nxt = ST_LS_ON;
                    else                                cnt_nxt = cnt + 1'b1;
                end
                ST_DM_WAIT: begin
                    if (lvl == LVL_HI)                  state_nxt = ST_HS_WAIT;
                    else if (lvl == LVL_LO)             state_nxt = ST_LS_WAIT;
                    else if (ccm_sel)                   state_nxt = ST_TRI;
                    else if (!sw_low_s)                 cnt_nxt = '0;
                    else if (cnt == CW'(DT_LS_CYC - 1)) state_nxt = ST_DEMU;
                    else                                cnt_nxt = cnt + 1'b1;
                end
                ST_DEMU: begin
                    if (lvl == LVL_HI)                     state_nxt = ST_HS_WAIT;
                    else if (lvl == LVL_LO)                state_nxt = ST_LS_ON;
                    else if (ccm_sel)                      state_nxt = ST_TRI;
                    else if (cnt == CW'(ZCD_BLANK_CYC)) begin
                        if (zc_s) state_nxt = ST_TRI;
                    end else                               cnt_nxt = cnt + 1'b1;
                end
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // Output decode
    always_comb begin
        hs_on = (state == ST_HS_ON);
        ls_on = (state == ST_LS_ON) || (state == ST_DEMU);
    end

    // High side only rises once the low-side enable was already released
    assert_hs_after_ls_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(!ls_on));

    // Leaving the dead-time wait requires the sensed low-side feedback
    assert_hs_needs_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) && $past(state) == ST_HS_WAIT) |-> $past(ls_low_s));

    // Emulated diode conducts while no zero cross is seen
    assert_demu_holds_ls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMU && !zc_s && lvl == LVL_MID && en_ok && !ccm_sel) |=> ls_on);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import gdrv_pkg::*;
#(
    parameter int unsigned DT_HS_CYC     = 2,
    parameter int unsigned DT_LS_CYC     = 2,
    parameter int unsigned TRI_HOLD_CYC  = 3,
    parameter int unsigned TRI_EXIT_CYC  = 4,
    parameter int unsigned ZCD_BLANK_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic       out_en,
    input  logic       ccm_sel,
    input  logic       uv_flag,
    input  logic       fb_ls_low,
    input  logic       fb_sw_low,
    input  logic       fb_zc,
    output logic       hs_gate,
    output logic       ls_gate
);
    localparam int unsigned FB_W = 3;

    logic [FB_W-1:0] fb_s;
    lvl_e            lvl_q;
    logic            en_ok;

    assign en_ok = out_en && !uv_flag;

    gdrv_sync #(.W(FB_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fb_zc, fb_sw_low, fb_ls_low}),
        .sync_out (fb_s)
    );

    gdrv_tri_filter #(.HOLD_CYC(TRI_HOLD_CYC)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_raw (pwm_lvl),
        .lvl_q   (lvl_q)
    );

    gdrv_fsm #(
        .DT_HS_CYC     (DT_HS_CYC),
        .DT_LS_CYC     (DT_LS_CYC),
        .TRI_EXIT_CYC  (TRI_EXIT_CYC),
        .ZCD_BLANK_CYC (ZCD_BLANK_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_ok    (en_ok),
        .ccm_sel  (ccm_sel),
        .lvl      (lvl_q),
        .ls_low_s (fb_s[0]),
        .sw_low_s (fb_s[1]),
        .zc_s     (fb_s[2]),
        .hs_on    (hs_gate),
        .ls_on    (ls_gate)
    );

    assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (!hs_gate && !ls_gate));

    assert_uv_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (!hs_gate && !ls_gate));

endmodule

// File: tb/buck_gate_seq_tb_top.sv
module buck_gate_seq_tb_top;

    localparam int DT_HS = 2;
    localparam int DT_LS = 2;
    localparam int HOLD  = 3;
    localparam int EXITC = 4;
    localparam int BLANK = 8;

    localparam logic [1:0] P_LO  = 2'b00;
    localparam logic [1:0] P_HI  = 2'b01;
    localparam logic [1:0] P_MID = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pwm_lvl;
    logic       out_en, ccm_sel, uv_flag;
    logic       fb_ls_low, fb_sw_low, fb_zc;
    logic       hs_gate, ls_gate;

    int checks = 0;
    int fails = 0;
    int issued = 0;
    int done_cnt = 0;
    int mutex_bad = 0;
    bit finished = 1'b0;

    int         q_wait[$];
    logic [1:0] q_exp[$];
    string      q_tag[$];

    int         m_wait;
    logic [1:0] m_exp;
    string      m_tag;

    always #10 clk = ~clk;

    buck_gate_seq #(
        .DT_HS_CYC(DT_HS), .DT_LS_CYC(DT_LS), .TRI_HOLD_CYC(HOLD),
        .TRI_EXIT_CYC(EXITC), .ZCD_BLANK_CYC(BLANK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .out_en(out_en),
        .ccm_sel(ccm_sel), .uv_flag(uv_flag), .fb_ls_low(fb_ls_low),
        .fb_sw_low(fb_sw_low), .fb_zc(fb_zc), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    // Driver side: queue an expectation, wait until the monitor has judged it
    task automatic expect_out(input int w, input logic h, input logic l, input string tag);
        q_wait.push_back(w);
        q_exp.push_back({h, l});
        q_tag.push_back(tag);
        issued++;
        wait (done_cnt == issued);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop, advance the stated number of falling edges, compare
    initial begin
        forever begin
            wait (q_wait.size() != 0);
            m_wait = q_wait.pop_front();
            m_exp  = q_exp.pop_front();
            m_tag  = q_tag.pop_front();
            repeat (m_wait) @(negedge clk);
            checks++;
            if ({hs_gate, ls_gate} !== m_exp) begin
                fails++;
                $display("FAIL %s: {hs,ls} actual=%b expected=%b", m_tag, {hs_gate, ls_gate}, m_exp);
            end
            done_cnt++;
        end
    end

    // R12: both enables high together is counted on every cycle
    always @(negedge clk) begin
        if (rst_n === 1'b1 && hs_gate && ls_gate) mutex_bad++;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pwm_lvl = P_LO; out_en = 1'b1; ccm_sel = 1'b1; uv_flag = 1'b0;
        fb_ls_low = 1'b1; fb_sw_low = 1'b0; fb_zc = 1'b0;
        tick(3);
        expect_out(0, 0, 0, "R6 reset state");
        rst_n = 1'b1;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay after reset");
        expect_out(1, 0, 1, "R6 low side on after reset");
        fb_ls_low = 1'b0; fb_sw_low = 1'b1;

        // R3 low to high, with late low-side feedback
        pwm_lvl = P_HI;
        expect_out(1, 0, 1, "R3 low side still on");
        expect_out(1, 0, 0, "R3 low side released");
        expect_out(6, 0, 0, "R3 waits for low-side feedback");
        fb_ls_low = 1'b1;
        expect_out(DT_HS + 1, 0, 0, "R3 dead time not yet over");
        expect_out(1, 1, 0, "R3 high side on");
        fb_sw_low = 1'b0;

        // R4 high to low
        pwm_lvl = P_LO;
        expect_out(1, 1, 0, "R4 high side still on");
        expect_out(1, 0, 0, "R4 high side released");
        expect_out(5, 0, 0, "R4 waits for switch node");
        fb_sw_low = 1'b1;
        expect_out(DT_LS + 1, 0, 0, "R4 dead time not yet over");
        expect_out(1, 0, 1, "R4 low side on");
        fb_ls_low = 1'b0;

        // R5 short mid-level glitch
        pwm_lvl = P_MID;
        tick(HOLD - 1);
        pwm_lvl = P_LO;
        expect_out(6, 0, 1, "R5 glitch ignored");

        // R7 continuous mode, tri-state from low side
        pwm_lvl = P_MID;
        expect_out(HOLD, 0, 1, "R5 hold-off not yet elapsed");
        expect_out(1, 0, 0, "R7 tri-state turns low side off");
        fb_ls_low = 1'b1;
        expect_out(10, 0, 0, "R7 stays off");

        // R6 exit to high, then R7 from high side
        pwm_lvl = P_HI;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay to high");
        expect_out(1, 1, 0, "R6 high side on after exit");
        fb_sw_low = 1'b0;
        pwm_lvl = P_MID;
        expect_out(HOLD, 1, 0, "R5 hold-off from high");
        expect_out(1, 0, 0, "R7 tri-state turns high side off");
        fb_sw_low = 1'b1;
        expect_out(10, 0, 0, "R7 no low side in continuous mode");

        // Back to high side for emulation test
        pwm_lvl = P_LO;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay to low");
        expect_out(1, 0, 1, "R6 low side on after exit");
        fb_ls_low = 1'b0;
        pwm_lvl = P_HI;
        expect_out(2, 0, 0, "R3 low side released");
        fb_ls_low = 1'b1;
        expect_out(DT_HS + 1, 0, 0, "R3 dead time");
        expect_out(1, 1, 0, "R3 high side on");
        fb_sw_low = 1'b0;

        // R8 and R9: emulation after high to tri-state
        ccm_sel = 1'b0;
        pwm_lvl = P_MID;
        expect_out(HOLD, 1, 0, "R8 hold-off");
        expect_out(1, 0, 0, "R8 high side off");
        expect_out(3, 0, 0, "R8 waits for switch node");
        fb_sw_low = 1'b1;
        expect_out(DT_LS + 1, 0, 0, "R8 dead time");
        expect_out(1, 0, 1, "R8 emulated diode on");
        fb_ls_low = 1'b0;
        expect_out(30, 0, 1, "R8 forward current keeps low side");
        fb_zc = 1'b1;
        expect_out(2, 0, 1, "R9 zero cross still synchronising");
        expect_out(1, 0, 0, "R9 zero cross turns low side off");
        expect_out(10, 0, 0, "R9 both stay off");
        fb_zc = 1'b0; fb_ls_low = 1'b1;

        // R10 blanking: zero cross already present at turn-on
        pwm_lvl = P_HI;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay to high");
        expect_out(1, 1, 0, "R6 high side on");
        fb_sw_low = 1'b0;
        fb_zc = 1'b1;
        pwm_lvl = P_MID;
        expect_out(HOLD, 1, 0, "R8 hold-off");
        expect_out(1, 0, 0, "R8 high side off");
        fb_sw_low = 1'b1;
        expect_out(DT_LS + 1, 0, 0, "R8 dead time");
        expect_out(1, 0, 1, "R10 emulated diode on");
        fb_ls_low = 1'b0;
        expect_out(BLANK, 0, 1, "R10 zero cross blanked");
        expect_out(1, 0, 0, "R10 zero cross honoured after blanking");
        fb_zc = 1'b0; fb_ls_low = 1'b1;

        // R11 emulation mode, low to tri-state
        pwm_lvl = P_LO;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay to low");
        expect_out(1, 0, 1, "R6 low side on");
        fb_ls_low = 1'b0;
        pwm_lvl = P_MID;
        expect_out(HOLD, 0, 1, "R11 hold-off");
        expect_out(1, 0, 0, "R11 both off");
        fb_ls_low = 1'b1;
        expect_out(10, 0, 0, "R11 stays off");

        // R1 disable
        ccm_sel = 1'b1;
        pwm_lvl = P_HI;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay to high");
        expect_out(1, 1, 0, "R6 high side on");
        fb_sw_low = 1'b0;
        out_en = 1'b0;
        expect_out(1, 0, 0, "R1 disable forces off");
        fb_sw_low = 1'b1;
        pwm_lvl = P_LO; ccm_sel = 1'b0;
        expect_out(10, 0, 0, "R1 pwm and mode ignored while disabled");
        ccm_sel = 1'b1;
        out_en = 1'b1;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay after enable");
        expect_out(1, 0, 1, "R6 low side on after enable");
        fb_ls_low = 1'b0;

        // R2 undervoltage
        uv_flag = 1'b1;
        expect_out(1, 0, 0, "R2 undervoltage forces off");
        fb_ls_low = 1'b1;
        pwm_lvl = P_HI;
        expect_out(8, 0, 0, "R2 held off");
        uv_flag = 1'b0;
        expect_out(EXITC + 1, 0, 0, "R6 exit delay after undervoltage");
        expect_out(1, 1, 0, "R6 high side on after undervoltage");

        tick(2);
        checks++;
        if (mutex_bad != 0) begin
            fails++;
            $display("FAIL R12: overlap cycles actual=%0d expected=0", mutex_bad);
        end
        finish_run();
    end

endmodule